// File: doc/BRIEF.md
# Set-Associative Cache Hit/Miss Profiler

This block models one level of a cache for profiling only. It takes in a stream of memory references, each an address plus an access length in bytes. It keeps a tag array arranged as sets and ways, and decides for each reference whether it hits or misses. It then updates two saturating counters, one for hits and one for misses. No data is stored. Every reference is treated as write-allocate, so reads and writes behave the same.

Replacement is most-recently-used ordering, held by physically shifting tags inside a set. A reference whose end address falls in the next set is looked up in both sets under one tag. It still counts as a single access.

Every miss emits a one-cycle forward strobe carrying the same address and length. A second instance can be chained behind it to model the next cache level. A reference whose two set indices are neither equal nor neighbours raises an error strobe and is not counted.

Top module: `cache_hit_profiler`

## Requirements
- R1: For address A, the set is (A >> log2(LINE_BYTES)) & (SETS-1) and the tag is A >> (log2(LINE_BYTES)+log2(SETS)), where SETS = SIZE_BYTES/(LINE_BYTES*WAYS).
- R2: A second set is computed the same way from A + length (modulo 2^ADDR_W). When it equals the first set, one set is looked up and the reference finishes in the cycle it is accepted.
- R3: When the second set equals (first set + 1) mod SETS, both sets are looked up with the first set's tag. The reference counts as one access: a hit only if both sets hit, otherwise one miss. `reqReady` is low for exactly one cycle after acceptance.
- R4: When the two sets are neither equal nor adjacent, `errFlag` pulses for one cycle. Neither counter changes, no tag moves and no forward strobe is raised.
- R5: Way 0 holds the most recent tag. On a hit in way i (lowest matching way), ways 0..i-1 move down one place and the tag enters way 0.
- R6: On a miss, every way moves down one place, the tag in the last way is dropped, and the new tag enters way 0.
- R7: Reset clears every tag to zero and there are no valid bits, so a reference with tag zero hits after reset.
- R8: A counted miss sets `fwdValid` high for one cycle, starting after the clock edge that finishes the reference, with `fwdAddr`/`fwdSize` equal to the request's address and length.
- R9: `hitCount` and `missCount` are CNT_W bits wide and stay at all-ones once they reach it.
- R10: `clrCnt` zeroes both counters at the next clock edge and takes priority over an increment in that edge.
- R11: After reset both counters are zero and `reqReady` is high. A reference that is not straddling leaves `reqReady` high, so one can be accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clrCnt | input | 1 | Synchronous counter clear |
| reqValid | input | 1 | Reference offered |
| reqReady | output | 1 | Reference can be accepted |
| reqAddr | input | ADDR_W | Reference byte address |
| reqSize | input | SIZE_W | Reference length in bytes |
| hitCount | output | CNT_W | Saturating hit counter |
| missCount | output | CNT_W | Saturating miss counter |
| fwdValid | output | 1 | Miss forward strobe to the next level |
| fwdAddr | output | ADDR_W | Forwarded address |
| fwdSize | output | SIZE_W | Forwarded length |
| errFlag | output | 1 | Set pair neither equal nor adjacent |

## Verification
A small two-way, four-set instance is driven with several kinds of pattern, each set against a model of the tag shifting.

- A cycle of three tags in one set separates MRU ordering from FIFO eviction.
- References that end exactly on a line edge, or wrap from the last set to set 0, separate the adjacency rule from a plain compare.
- Overlong lengths exercise the error path. A repeat of an earlier tag afterwards shows that the tags were left untouched.
- A long pseudo-random stream over a narrow address window mixes hits, misses, straddles and errors.
- A run of distinct tags drives the miss counter into saturation.
- A clear on the same edge as a miss shows that the clear wins while the forward strobe still fires.

// File: rtl/chp_pkg.sv
package chp_pkg;

  // Strobes from the sequencer to the tag datapath for the current cycle.
  typedef struct packed {
    logic capture;    // latch the accepted request
    logic update;     // rewrite the looked-up set
    logic countHit;   // one finished access that hit
    logic countMiss;  // one finished access that missed
    logic flagErr;    // inconsistent set pair
  } ctrlStrobe_t;

endpackage

// File: rtl/chp_satcnt.sv
module chp_satcnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       cnt <= '0;
    else if (clr)                    cnt <= '0;
    else if (inc && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
  end

  p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);

  p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> cnt == '0);

endmodule

// File: rtl/chp_ctrl.sv
module chp_ctrl
  import chp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        setEq,
  input  logic        setAdj,
  input  logic        lookHit,
  output logic        reqReady,
  output logic        secondPass,
  output ctrlStrobe_t strobe
);

  typedef enum logic {ST_IDLE, ST_SECOND} state_t;

  state_t state, nextState;
  logic   firstMiss, nextFirstMiss;

  assign reqReady   = (state == ST_IDLE);
  assign secondPass = (state == ST_SECOND);

  always_comb begin
    strobe        = '0;
    nextState     = state;
    nextFirstMiss = firstMiss;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          if (setEq) begin
            strobe.update    = 1'b1;
            strobe.countHit  = lookHit;
            strobe.countMiss = !lookHit;
          end else if (setAdj) begin
            strobe.update = 1'b1;
            nextFirstMiss = !lookHit;
            nextState     = ST_SECOND;
          end else begin
            strobe.flagErr = 1'b1;
          end
        end
      end
      ST_SECOND: begin
        strobe.update    = 1'b1;
        strobe.countHit  = lookHit && !firstMiss;
        strobe.countMiss = !lookHit || firstMiss;
        nextState        = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      firstMiss <= 1'b0;
    end else begin
      state     <= nextState;
      firstMiss <= nextFirstMiss;
    end
  end

  // R3: the second half of a straddle always finishes in one cycle
  p_second_one_cycle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SECOND) |=> (state == ST_IDLE));

  // R11: a non-straddling accept keeps the port open
  p_single_keeps_ready_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && setEq) |=> reqReady);

  p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.countHit, strobe.countMiss, strobe.flagErr}));

endmodule

// File: rtl/chp_datapath.sv
module chp_datapath
  import chp_pkg::*;
#(
  parameter int SIZE_BYTES = 4096,
  parameter int LINE_BYTES = 32,
  parameter int WAYS       = 4,
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 8,
  parameter int CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrCnt,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              secondPass,
  input  ctrlStrobe_t       strobe,
  output logic              setEq,
  output logic              setAdj,
  output logic              lookHit,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount,
  output logic              fwdValid,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [SIZE_W-1:0] fwdSize,
  output logic              errFlag
);

  localparam int SETS     = SIZE_BYTES / (LINE_BYTES * WAYS);
  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int IDX_BITS = $clog2(SETS);
  localparam int SET_W    = (IDX_BITS > 0) ? IDX_BITS : 1;
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_BITS;
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [ADDR_W-1:0] SET_MASK = ADDR_W'(SETS - 1);

  logic [ADDR_W-1:0] heldAddr, curAddr, sumAddr;
  logic [SIZE_W-1:0] heldSize, curSize;
  logic [SET_W-1:0]  setA, setB, setNext, lookSet;
  logic [TAG_W-1:0]  curTag;
  logic [TAG_W-1:0]  tagArr [SETS][WAYS];
  logic [TAG_W-1:0]  row    [WAYS];
  logic [TAG_W-1:0]  newRow [WAYS];
  logic [WAY_W-1:0]  hitIdx;

  // Request source: live port on the first pass, latched copy on the second
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr <= '0;
      heldSize <= '0;
    end else if (strobe.capture) begin
      heldAddr <= reqAddr;
      heldSize <= reqSize;
    end
  end

  assign curAddr = secondPass ? heldAddr : reqAddr;
  assign curSize = secondPass ? heldSize : reqSize;
  assign sumAddr = curAddr + ADDR_W'(curSize);

  // Set and tag selection by plain bit slicing
  assign setA    = SET_W'((curAddr >> OFF_W) & SET_MASK);
  assign setB    = SET_W'((sumAddr >> OFF_W) & SET_MASK);
  assign setNext = SET_W'((32'(setA) + 32'd1) % 32'(SETS));
  assign curTag  = TAG_W'(curAddr >> (OFF_W + IDX_BITS));
  assign setEq   = (setA == setB);
  assign setAdj  = (setNext == setB);
  assign lookSet = secondPass ? setB : setA;

  // Lookup: lowest matching way wins
  always_comb begin
    for (int w = 0; w < WAYS; w++) row[w] = tagArr[lookSet][w];
    hitIdx  = '0;
    lookHit = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (row[w] == curTag) begin
        hitIdx  = WAY_W'(w);
        lookHit = 1'b1;
      end
    end
  end

  // MRU reorder: shift ways above the hit (or all ways on a miss) down by one
  always_comb begin
    newRow[0] = curTag;
    for (int w = 1; w < WAYS; w++)
      newRow[w] = (!lookHit || WAY_W'(w) <= hitIdx) ? row[w-1] : row[w];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          tagArr[s][w] <= '0;
    end else if (strobe.update) begin
      for (int w = 0; w < WAYS; w++)
        tagArr[lookSet][w] <= newRow[w];
    end
  end

  chp_satcnt #(.CNT_W(CNT_W)) uHitCnt (
    .clk(clk), .rstN(rstN), .clr(clrCnt), .inc(strobe.countHit), .cnt(hitCount)
  );

  chp_satcnt #(.CNT_W(CNT_W)) uMissCnt (
    .clk(clk), .rstN(rstN), .clr(clrCnt), .inc(strobe.countMiss), .cnt(missCount)
  );

  // Forward and error strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdValid <= 1'b0;
      fwdAddr  <= '0;
      fwdSize  <= '0;
      errFlag  <= 1'b0;
    end else begin
      fwdValid <= strobe.countMiss;
      errFlag  <= strobe.flagErr;
      if (strobe.countMiss) begin
        fwdAddr <= curAddr;
        fwdSize <= curSize;
      end
    end
  end

  p_mru_front_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.update |=> tagArr[$past(lookSet)][0] == $past(curTag));

  p_fwd_with_miss_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && !$past(clrCnt) && $past(missCount) != '1)
      |-> missCount == CNT_W'($past(missCount) + 1'b1));

  p_err_no_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !$past(clrCnt)) |-> ($stable(hitCount) && $stable(missCount)));

  p_err_no_fwd_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(errFlag && fwdValid));

endmodule

// File: rtl/cache_hit_profiler.sv
module cache_hit_profiler
  import chp_pkg::*;
#(
  parameter int SIZE_BYTES = 4096,
  parameter int LINE_BYTES = 32,
  parameter int WAYS       = 4,
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 8,
  parameter int CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrCnt,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount,
  output logic              fwdValid,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [SIZE_W-1:0] fwdSize,
  output logic              errFlag
);

  ctrlStrobe_t strobe;
  logic        setEq, setAdj, lookHit, secondPass;

  initial begin
    p_pow2_size_r1: assert ((SIZE_BYTES & (SIZE_BYTES - 1)) == 0);
    p_pow2_line_r1: assert ((LINE_BYTES & (LINE_BYTES - 1)) == 0);
    p_pow2_ways_r1: assert ((WAYS & (WAYS - 1)) == 0);
  end

  chp_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .setEq(setEq), .setAdj(setAdj), .lookHit(lookHit),
    .reqReady(reqReady), .secondPass(secondPass), .strobe(strobe)
  );

  chp_datapath #(
    .SIZE_BYTES(SIZE_BYTES), .LINE_BYTES(LINE_BYTES), .WAYS(WAYS),
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)
  ) uData (
    .clk(clk), .rstN(rstN), .clrCnt(clrCnt),
    .reqAddr(reqAddr), .reqSize(reqSize),
    .secondPass(secondPass), .strobe(strobe),
    .setEq(setEq), .setAdj(setAdj), .lookHit(lookHit),
    .hitCount(hitCount), .missCount(missCount),
    .fwdValid(fwdValid), .fwdAddr(fwdAddr), .fwdSize(fwdSize),
    .errFlag(errFlag)
  );

endmodule

// File: tb/cache_hit_profiler_test.sv
module cache_hit_profiler_test;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_MAX    = 63;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clrCnt = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqSize = '0;
  logic [5:0]  hitCount, missCount;
  logic        fwdValid, errFlag;
  logic [15:0] fwdAddr;
  logic [7:0]  fwdSize;

  cache_hit_profiler #(
    .SIZE_BYTES(128), .LINE_BYTES(16), .WAYS(2),
    .ADDR_W(16), .SIZE_W(8), .CNT_W(6)
  ) uut (
    .clk(clk), .rstN(rstN), .clrCnt(clrCnt),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize(reqSize),
    .hitCount(hitCount), .missCount(missCount),
    .fwdValid(fwdValid), .fwdAddr(fwdAddr), .fwdSize(fwdSize),
    .errFlag(errFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int mTag [4][2];
  int expHit = 0;
  int expMiss = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int setOf(input int a);
    return (a >> 4) & 3;
  endfunction

  task automatic mLook(input int s, input int t, output bit hit);
    int found = -1;
    int last;
    for (int i = 0; i < 2; i++) if (found < 0 && mTag[s][i] == t) found = i;
    hit  = (found >= 0);
    last = hit ? found : 1;
    for (int j = last; j > 0; j--) mTag[s][j] = mTag[s][j-1];
    mTag[s][0] = t;
  endtask

  task automatic mRef(input int a, input int sz, output bit miss,
                      output bit err, output bit two);
    int s1 = setOf(a);
    int s2 = setOf((a + sz) & 16'hFFFF);
    int t  = a >> 6;
    bit h1, h2;
    miss = 0; err = 0; two = 0;
    if (s1 == s2) begin
      mLook(s1, t, h1);
      miss = !h1;
    end else if (((s1 + 1) % 4) == s2) begin
      two = 1;
      mLook(s1, t, h1);
      mLook(s2, t, h2);
      miss = !(h1 && h2);
    end else begin
      err = 1;
    end
    if (!err) begin
      if (miss) expMiss = (expMiss < CNT_MAX) ? expMiss + 1 : CNT_MAX;
      else      expHit  = (expHit  < CNT_MAX) ? expHit  + 1 : CNT_MAX;
    end
  endtask

  task automatic doReq(input int a, input int sz, input string req, input bit clr = 0);
    bit eMiss, eErr, eTwo;
    bit sFwd, sErr, stalled;
    int sFa, sFs;
    mRef(a, sz, eMiss, eErr, eTwo);
    if (clr) begin expHit = 0; expMiss = 0; end
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 16'(a); reqSize = 8'(sz); clrCnt = clr;
    @(negedge clk);
    reqValid = 1'b0; clrCnt = 1'b0;
    stalled = 0;
    sFwd = fwdValid; sErr = errFlag; sFa = int'(fwdAddr); sFs = int'(fwdSize);
    if (!reqReady) begin
      stalled = 1;
      @(negedge clk);
      sFwd = fwdValid; sErr = errFlag; sFa = int'(fwdAddr); sFs = int'(fwdSize);
    end
    check(int'(hitCount) == expHit, req, "hitCount", int'(hitCount), expHit);
    check(int'(missCount) == expMiss, req, "missCount", int'(missCount), expMiss);
    check(sFwd == (eMiss && !eErr), {req, " R8"}, "fwdValid", int'(sFwd), int'(eMiss && !eErr));
    check(sErr == eErr, {req, " R4"}, "errFlag", int'(sErr), int'(eErr));
    check(stalled == eTwo, {req, " R3/R11"}, "stall", int'(stalled), int'(eTwo));
    if (eMiss && !eErr) begin
      check(sFa == a, "R8", "fwdAddr", sFa, a);
      check(sFs == sz, "R8", "fwdSize", sFs, sz);
    end
  endtask

  task automatic pulseClear();
    @(negedge clk); clrCnt = 1'b1;
    @(negedge clk); clrCnt = 1'b0;
    expHit = 0; expMiss = 0;
    check(hitCount == 0 && missCount == 0, "R10", "counters after clear",
          int'(hitCount) + int'(missCount), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [31:0] lcg = 32'h1234_5678;
    for (int s = 0; s < 4; s++) for (int w = 0; w < 2; w++) mTag[s][w] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(hitCount == 0, "R11", "reset hitCount", int'(hitCount), 0);
    check(missCount == 0, "R11", "reset missCount", int'(missCount), 0);
    check(reqReady == 1'b1, "R11", "reset reqReady", int'(reqReady), 1);
    check(!fwdValid && !errFlag, "R11", "reset strobes", int'(fwdValid) + int'(errFlag), 0);

    // R7: zero tag hits on cleared array
    doReq(16'h0005, 1, "R7");
    check(hitCount == 1, "R7", "zero tag hit", int'(hitCount), 1);

    // R1/R5/R6: three tags cycling through set 1
    doReq(16'h0050, 2, "R1");  // tag 1 miss
    doReq(16'h0090, 2, "R1");  // tag 2 miss
    doReq(16'h0050, 2, "R5");  // tag 1 hit, moves to front
    doReq(16'h00D0, 2, "R6");  // tag 3 miss evicts tag 2
    doReq(16'h0090, 2, "R6");  // tag 2 was evicted: miss
    doReq(16'h00D4, 1, "R5");  // tag 3 still present

    // R2: end lands exactly on next line edge -> straddle rule
    doReq(16'h004C, 4, "R2");
    doReq(16'h0044, 4, "R2");
    // R3: straddle, and wrap from set 3 to set 0
    doReq(16'h004E, 4, "R3");
    doReq(16'h003E, 4, "R3");
    doReq(16'h013E, 4, "R3");
    doReq(16'h003E, 4, "R3");

    // R4: overlong reference, then confirm tags untouched
    doReq(16'h0040, 48, "R4");
    doReq(16'h0041, 1, "R4");

    // R10: clear alone, then clear on the same edge as a miss
    pulseClear();
    doReq(16'h0700, 1, "R10", 1'b1);

    // R9: saturation of the miss counter
    pulseClear();
    for (int i = 1; i <= 70; i++) doReq(i * 64, 1, "R9");
    check(missCount == 6'd63, "R9", "miss saturated", int'(missCount), 63);

    // Mixed pseudo-random sweep
    pulseClear();
    for (int n = 0; n < 600; n++) begin
      int a, sz;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      a  = int'((lcg >> 8) & 32'd1023);
      sz = 1 + int'((lcg >> 20) % 32'd20);
      doReq(a, sz, "R1 sweep");
      if (n % 40 == 39) pulseClear();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule